// File: doc/BRIEF.md
# Overflow Event Counter with Staged Byte Access

This block counts overflow events reported by a timer core. The count is 20 bits wide and is reached through a narrow register bus as three byte slots. Slot 0 holds the least significant byte. Slot 1 holds the middle byte. Slot 2 holds the top four bits in its low nibble. An overflow pulse adds one to the count, but only while the timer reports that it is running.

Reads stay coherent across the three slots. Reading slot 0 returns the live low byte and, in that same cycle, captures the upper bits into a snapshot. Later reads of slots 1 and 2 return that snapshot.

Writes to slots 0 and 1 only fill staging registers. A write to slot 2 loads the whole count at once, from the staged bytes and the written nibble. If a counted overflow arrives in the same cycle as that load, the count takes the loaded value plus one, so no event is lost. The count width and the bus width are both parameters. The number of slots, the select width and the width of the top slot are derived from them.

Top module: `ovf_tally`

## Requirements
- R1: Slot 0 maps count bits [7:0], slot 1 maps bits [15:8] and slot 2 maps bits [19:16] in its bits [3:0]. In general, slot k maps bits starting at k*BYTE_W, and the top slot is CNT_W-2*BYTE_W bits wide. Bits of slot 2 above the top width read as zero, and writes to them are ignored. A select value beyond slot 2 reads zero, and writing it changes nothing.
- R2: In each cycle where ovf_pulse and tmr_run are both high and no commit occurs, the count increases by exactly one in the next cycle. The all-ones value wraps to zero.
- R3: An ovf_pulse while tmr_run is low does not change the count.
- R4: A read with bus_sel=0 returns the live count bits [7:0] combinationally in the same cycle, and captures the count's upper bits at the next clock edge. Reads of slots 1 and 2 return the captured bits, unaffected by later increments, until the next slot 0 read.
- R5: A write with bus_sel=0 or bus_sel=1 updates only the staging register of that slot. The count does not change because of it.
- R6: A write with bus_sel=2 (the commit) loads {bus_wdata[3:0], staged slot 1, staged slot 0} into the count at the next edge. This happens whether tmr_run is high or low.
- R7: A commit in the same cycle as a counted overflow pulse loads the committed value plus one, modulo 2^CNT_W.
- R8: The staged bytes keep their values across commits. A commit with no prior slot 0 or slot 1 write reuses the bytes staged earlier.
- R9: After reset the count, the staging registers and the snapshot are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_pulse | input | 1 | One-cycle overflow event from the timer core |
| tmr_run | input | 1 | High while the timer is running; gates counting |
| bus_sel | input | SEL_W (2) | Slot select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BYTE_W (8) | Write data |
| bus_rdata | output | BYTE_W (8) | Read data for the selected slot (combinational) |

## Verification
The bench builds the block with CNT_W=10 and BYTE_W=4. This keeps three slots and leaves a two-bit top slot, so slot 2 still has unused upper bits to test and slot select 3 is still unmapped. With only 1024 count values, the bench commits every value, alternating commits with and without a coinciding counted pulse. It also counts through the wrap edge one pulse at a time. These sweeps cover the full load path, the plus-one merge and the modular wrap, which could not be swept at 20 bits.

// File: rtl/ovf_tally_pkg.sv
package ovf_tally_pkg;

   // number of bus slots needed to cover a count of cw bits with bw-bit slots
   function automatic int slot_count(input int cw, input int bw);
      return (cw + bw - 1) / bw;
   endfunction

   // width of the most significant slot
   function automatic int top_width(input int cw, input int bw);
      return cw - (slot_count(cw, bw) - 1) * bw;
   endfunction

   function automatic int sel_width(input int cw, input int bw);
      return (slot_count(cw, bw) < 2) ? 1 : $clog2(slot_count(cw, bw));
   endfunction

endpackage

// File: rtl/ovf_tally_count.sv
module ovf_tally_count #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt
);

   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] nxt;

   // a load replaces the base value; a coinciding increment still applies
   always_comb begin
      base = load ? load_val : cnt;
      nxt  = base + {{(CNT_W-1){1'b0}}, inc};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load || inc)
         cnt <= nxt;
   end

endmodule

// File: rtl/ovf_tally_stage.sv
module ovf_tally_stage #(
   parameter int BYTE_W = 8,
   parameter int NSTG   = 2,
   parameter int SEL_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [SEL_W-1:0]         sel,
   input  logic [BYTE_W-1:0]        wdata,
   output logic [NSTG*BYTE_W-1:0]   stage_q
);

   for (genvar k = 0; k < NSTG; k++) begin : g_slot
      logic hit;
      assign hit = wr && (sel == SEL_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[k*BYTE_W +: BYTE_W] <= '0;
         else if (hit)
            stage_q[k*BYTE_W +: BYTE_W] <= wdata;
      end
   end

endmodule

// File: rtl/ovf_tally_view.sv
module ovf_tally_view #(
   parameter int CNT_W  = 20,
   parameter int BYTE_W = 8,
   parameter int NREG   = 3,
   parameter int TOP_W  = 4,
   parameter int SEL_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    capture,
   input  logic [SEL_W-1:0]        sel,
   input  logic [CNT_W-1:0]        cnt,
   output logic [CNT_W-BYTE_W-1:0] snap,
   output logic [BYTE_W-1:0]       rdata
);

   localparam int SNAP_W = CNT_W - BYTE_W;

   logic [BYTE_W-1:0] words [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         snap <= '0;
      else if (capture)
         snap <= cnt[CNT_W-1:BYTE_W];
   end

   assign words[0] = cnt[BYTE_W-1:0];

   for (genvar k = 1; k < NREG; k++) begin : g_word
      if (k == NREG - 1) begin : g_top
         if (TOP_W == BYTE_W) begin : g_full
            assign words[k] = snap[SNAP_W-1 -: BYTE_W];
         end else begin : g_part
            assign words[k] = {{(BYTE_W-TOP_W){1'b0}}, snap[SNAP_W-1 -: TOP_W]};
         end
      end else begin : g_mid
         assign words[k] = snap[(k-1)*BYTE_W +: BYTE_W];
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NREG; k++)
         if (sel == SEL_W'(k))
            rdata = words[k];
   end

endmodule

// File: rtl/ovf_tally.sv
module ovf_tally
   import ovf_tally_pkg::*;
#(
   parameter  int CNT_W  = 20,
   parameter  int BYTE_W = 8,
   localparam int NREG   = slot_count(CNT_W, BYTE_W),
   localparam int SEL_W  = sel_width(CNT_W, BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ovf_pulse,
   input  logic              tmr_run,
   input  logic [SEL_W-1:0]  bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata
);

   localparam int TOP_W = top_width(CNT_W, BYTE_W);
   localparam int NSTG  = NREG - 1;

   if (BYTE_W < 2) begin : g_bad_byte
      $error("ovf_tally: BYTE_W must be at least 2");
   end
   if (CNT_W <= BYTE_W) begin : g_bad_cnt
      $error("ovf_tally: CNT_W must exceed BYTE_W");
   end

   logic                    inc;
   logic                    commit;
   logic                    capture;
   logic [CNT_W-1:0]        cnt_q;
   logic [CNT_W-1:0]        load_val;
   logic [NSTG*BYTE_W-1:0]  stage_q;
   logic [CNT_W-BYTE_W-1:0] snap_q;
   logic                    unused_wd;

   assign inc       = ovf_pulse && tmr_run;
   assign commit    = bus_wr && (bus_sel == SEL_W'(NREG-1));
   assign capture   = bus_rd && (bus_sel == '0);
   assign load_val  = {bus_wdata[TOP_W-1:0], stage_q};
   assign unused_wd = ^bus_wdata;

   ovf_tally_stage #(
      .BYTE_W (BYTE_W),
      .NSTG   (NSTG),
      .SEL_W  (SEL_W)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .sel     (bus_sel),
      .wdata   (bus_wdata),
      .stage_q (stage_q)
   );

   ovf_tally_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc),
      .load     (commit),
      .load_val (load_val),
      .cnt      (cnt_q)
   );

   ovf_tally_view #(
      .CNT_W  (CNT_W),
      .BYTE_W (BYTE_W),
      .NREG   (NREG),
      .TOP_W  (TOP_W),
      .SEL_W  (SEL_W)
   ) u_view (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .sel     (bus_sel),
      .cnt     (cnt_q),
      .snap    (snap_q),
      .rdata   (bus_rdata)
   );

endmodule

// File: rtl/ovf_tally_chk.sv
module ovf_tally_chk #(
   parameter int CNT_W  = 20,
   parameter int BYTE_W = 8,
   parameter int NREG   = 3,
   parameter int TOP_W  = 4,
   parameter int SEL_W  = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ovf_pulse,
   input logic                        tmr_run,
   input logic [SEL_W-1:0]            bus_sel,
   input logic                        bus_rd,
   input logic                        bus_wr,
   input logic [BYTE_W-1:0]           bus_wdata,
   input logic [BYTE_W-1:0]           bus_rdata,
   input logic [CNT_W-1:0]            cnt,
   input logic [(NREG-1)*BYTE_W-1:0]  stage,
   input logic [CNT_W-BYTE_W-1:0]     snap
);

   logic             c_inc;
   logic             c_commit;
   logic             c_stw;
   logic [CNT_W-1:0] c_load;

   assign c_inc    = ovf_pulse && tmr_run;
   assign c_commit = bus_wr && (int'(bus_sel) == NREG - 1);
   assign c_stw    = bus_wr && (int'(bus_sel) < NREG - 1);
   assign c_load   = {bus_wdata[TOP_W-1:0], stage};

   p_top_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_sel) == NREG - 1) |-> ((bus_rdata >> TOP_W) == '0));

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_inc && !c_commit) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_run && !c_commit) |=> (cnt == $past(cnt)));

   p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_sel == '0) |=> $stable(snap));

   p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !c_stw |=> $stable(stage));

   p_commit_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_commit && !c_inc) |=> (cnt == $past(c_load)));

   p_commit_plus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (c_commit && c_inc) |=> (cnt == CNT_W'($past(c_load) + 1'b1)));

endmodule

bind ovf_tally ovf_tally_chk #(
   .CNT_W  (CNT_W),
   .BYTE_W (BYTE_W),
   .NREG   (NREG),
   .TOP_W  (TOP_W),
   .SEL_W  (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ovf_pulse (ovf_pulse),
   .tmr_run   (tmr_run),
   .bus_sel   (bus_sel),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .cnt       (cnt_q),
   .stage     (stage_q),
   .snap      (snap_q)
);

// File: tb/sim_ovf_tally.sv
`timescale 1ns/1ps
module sim_ovf_tally;

   localparam int CW   = 10;
   localparam int BW   = 4;
   localparam int MASK = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ovf_pulse = 1'b0;
   logic          tmr_run = 1'b0;
   logic [1:0]    bus_sel = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [BW-1:0] bus_wdata = '0;
   logic [BW-1:0] bus_rdata;

   int n_vec  = 0;
   int n_fail = 0;
   int exp_c  = 0;
   int st0    = 0;
   int st1    = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   ovf_tally #(.CNT_W(CW), .BYTE_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .tmr_run(tmr_run),
      .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic chk(input string tag, input int act, input int expv);
      n_vec++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, expv);
      end
   endtask

   // one bus cycle; q is rdata sampled within the cycle; model is updated
   task automatic op(input int s, input bit rd, input bit wr, input int d,
                     input bit ovf, input bit run, output int q);
      @(negedge clk);
      bus_sel = 2'(s); bus_rd = rd; bus_wr = wr; bus_wdata = BW'(d);
      ovf_pulse = ovf; tmr_run = run;
      #1 q = int'(bus_rdata);
      @(posedge clk);
      #1;
      bus_rd = 0; bus_wr = 0; ovf_pulse = 0;
      if (wr && s == 2)
         exp_c = (((d & 3) << 8) | (st1 << 4) | st0) + int'(ovf && run);
      else
         exp_c = exp_c + int'(ovf && run);
      exp_c &= MASK;
      if (wr && s == 0) st0 = d & 15;
      if (wr && s == 1) st1 = d & 15;
   endtask

   task automatic read_all(input string tag);
      int q;
      op(0, 1, 0, 0, 0, 0, q); chk({tag, " slot0"}, q, exp_c & 15);
      op(1, 1, 0, 0, 0, 0, q); chk({tag, " slot1"}, q, (exp_c >> 4) & 15);
      op(2, 1, 0, 0, 0, 0, q); chk({tag, " slot2"}, q, (exp_c >> 8) & 3);
   endtask

   task automatic commit(input int v, input bit ovf, input bit run);
      int q;
      op(0, 0, 1, v & 15, 0, run, q);
      op(1, 0, 1, (v >> 4) & 15, 0, run, q);
      op(2, 0, 1, ((v >> 8) & 3) | 12, ovf, run, q); // R1: junk in bits [3:2]
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      int q;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R9: reset state
      read_all("R9 reset");
      // R9: staged bytes are zero -> top-only commit yields {d,0,0}
      op(2, 0, 1, 1, 0, 0, q);
      read_all("R9 stage zero");

      // R6/R7: every value committed, odd values with coinciding pulse
      for (int v = 0; v <= MASK; v++) begin
         commit(v, v[0], 1'b1);
         read_all(v[0] ? "R7 commit+1" : "R6 commit");
      end

      // R6: commit while idle, pulse ignored
      commit(10'h2A5, 1'b1, 1'b0);
      read_all("R6 idle commit");

      // R2: count through the wrap
      commit(MASK - 5, 1'b0, 1'b1);
      for (int i = 0; i < 10; i++) begin
         op(3, 0, 0, 0, 1, 1, q);
         read_all("R2 step/wrap");
      end

      // R3: pulses while idle
      for (int i = 0; i < 5; i++) op(3, 0, 0, 0, 1, 0, q);
      read_all("R3 idle pulses");

      // R5: staging writes leave count alone
      op(0, 0, 1, 9, 0, 1, q);
      op(1, 0, 1, 6, 0, 1, q);
      read_all("R5 stage only");

      // R8: top-only commit reuses staged 6,9
      op(2, 0, 1, 2, 0, 1, q);
      chk("R8 reuse", exp_c, 10'h269);
      read_all("R8 reuse");

      // R1: select 3 reads zero, write ignored
      op(3, 1, 1, 15, 0, 1, q);
      chk("R1 slot3 read", q, 0);
      read_all("R1 slot3 write");

      // R4: snapshot coherence
      commit(10'h1FE, 1'b0, 1'b1);
      op(0, 1, 0, 0, 0, 1, q);
      chk("R4 live low", q, 4'hE);
      for (int i = 0; i < 3; i++) op(3, 0, 0, 0, 1, 1, q);
      op(1, 1, 0, 0, 0, 1, q);
      chk("R4 held mid", q, 4'hF);
      op(2, 1, 0, 0, 0, 1, q);
      chk("R4 held top", q, 1);
      read_all("R4 refresh");
      chk("R4 model", exp_c, 10'h201);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule